// File: doc/BRIEF.md
# Outbound Window Translator

This block converts local 64-bit request addresses into link-side bus addresses for a root port. It holds a small set of outbound windows (four by default). Each window has a 64-bit base, a 32-bit inclusive upper bound, a 64-bit target, a transaction kind and an enable bit. Software does not address the windows directly. It first writes a selector register that names a direction and a window number, and then reaches that window's fields through a fixed group of offsets on a simple 32-bit register port.

On the request side, each valid address is checked against every enabled window in the same cycle. When a window claims the address, the block reports one cycle later:
- a hit flag,
- the number of the winning window,
- the translated address, which is the request address minus the window base plus the window target,
- the window's transaction kind: memory, I/O, or configuration type 0 or type 1.

For configuration windows, the target holds the bus, device and function numbers, so they appear in the translated address.

Register reads are served by a two-state machine. In RD_IDLE, a read request moves it to RD_RESP, and a write or no request keeps it in RD_IDLE. In RD_RESP, a further read keeps it in RD_RESP, and anything else returns it to RD_IDLE. The read-valid output is high exactly while the machine is in RD_RESP, and the read data captured at the request edge is presented during that cycle.

Top module: `obx_top`

## Requirements
- R1: After reset, every window is disabled, every register reads zero, and a translation request reports no hit.
- R2: The selector register at offset 0x900 stores bit 31 as direction (1 = inbound, 0 = outbound) and the low two bits as window number. It reads back as {bit31, zeros, window number}.
- R3: With an outbound selection, the selected window's fields are read and written at these offsets:
  - 0x904: kind, in bits 4:0; reads return zeros above.
  - 0x908: enable in bit 31 and bar request in bit 30; reads return zeros elsewhere.
  - 0x90C and 0x910: lower and upper base.
  - 0x914: bound.
  - 0x918 and 0x91C: lower and upper target.
  
  Read data is valid on the cycle after the read request, with the read-valid output high only in that cycle.
- R4: A window takes part in matching only while its enable bit is 1. The bar request bit is stored and read back but does not change matching.
- R5: A window claims an address when it is enabled, the address bits 63:32 equal the upper base, and the address bits 31:0 lie between the lower base and the bound, with both ends included.
- R6: The translated address is the request address minus {upper base, lower base} plus {upper target, lower target}, taken modulo 2^64.
- R7: The kind output carries the winning window's kind code (0 memory, 2 I/O, 4 configuration type 0, 5 configuration type 1). For a configuration window, the bus, device and function numbers placed in lower target bits 31:24, 23:19 and 18:16 appear unchanged in the translated address when the offset is below 64 KiB.
- R8: When several enabled windows claim an address, the lowest-numbered window wins.
- R9: When no window claims an address, or no request is presented, the hit flag, window number, translated address and kind are all zero.
- R10: While the selector names the inbound direction, writes to window offsets change nothing and reads of window offsets return zero.
- R11: The result for a request appears one cycle after the request, with its own valid flag. A register write in the same cycle as a request only affects requests in later cycles.
- R12: Reads of offsets outside 0x900 to 0x91C return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Register access request |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read response strobe |
| xl_valid | input | 1 | Translation request valid |
| xl_addr | input | 64 | Local request address |
| xo_valid | output | 1 | Translation result valid |
| xo_hit | output | 1 | A window claimed the address |
| xo_idx | output | 2 | Winning window number |
| xo_addr | output | 64 | Translated bus address |
| xo_kind | output | 5 | Transaction kind of the winning window |

## Verification
A register write and a translation request can land on the same clock edge. The sharp case is a write that disables, or moves, the window the request would hit. The bench provokes this by driving a disabling write to control 2 in the same cycle as a request to that window's base, and then repeating the request on the next cycle. A behavioural model, which applies lookups before writes on each edge, expects a hit on the first result and a miss on the second, and it is compared with the outputs on every cycle.

// File: rtl/obx_pkg.sv
package obx_pkg;
    localparam int unsigned CFG_AW = 12;
    localparam int unsigned DW     = 32;

    localparam logic [CFG_AW-1:0] OFS_VIEW  = 12'h900;
    localparam logic [CFG_AW-1:0] OFS_CTL1  = 12'h904;
    localparam logic [CFG_AW-1:0] OFS_CTL2  = 12'h908;
    localparam logic [CFG_AW-1:0] OFS_LBASE = 12'h90C;
    localparam logic [CFG_AW-1:0] OFS_UBASE = 12'h910;
    localparam logic [CFG_AW-1:0] OFS_BOUND = 12'h914;
    localparam logic [CFG_AW-1:0] OFS_LTGT  = 12'h918;
    localparam logic [CFG_AW-1:0] OFS_UTGT  = 12'h91C;

    // one outbound window
    typedef struct packed {
        logic [4:0]    kind;
        logic          en;
        logic          bar;
        logic [DW-1:0] lbase;
        logic [DW-1:0] ubase;
        logic [DW-1:0] bound;
        logic [DW-1:0] ltgt;
        logic [DW-1:0] utgt;
    } win_t;

    typedef enum logic {RD_IDLE, RD_RESP} rd_state_e;
endpackage

// File: rtl/obx_regs.sv
module obx_regs
    import obx_pkg::*;
#(
    parameter int unsigned NWIN  = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic                 cfg_wr,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    output logic                 cfg_rvalid,
    output win_t [NWIN-1:0]      win_o
);
    rd_state_e          state_q, state_d;
    win_t [NWIN-1:0]    win_q;
    logic               vp_dir;
    logic [IDX_W-1:0]   vp_idx;
    logic [DW-1:0]      rd_mux;
    logic               rd_req, wr_req, sel_ok;

    assign rd_req = cfg_en && !cfg_wr;
    assign wr_req = cfg_en && cfg_wr;
    assign sel_ok = !vp_dir && (int'(vp_idx) < NWIN);
    assign win_o  = win_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_req ? RD_RESP : RD_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        cfg_rvalid = (state_q == RD_RESP);
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        if (cfg_addr == OFS_VIEW) begin
            rd_mux = {vp_dir, {(DW-1-IDX_W){1'b0}}, vp_idx};
        end else if (sel_ok) begin
            unique case (cfg_addr)
                OFS_CTL1:  rd_mux = {{(DW-5){1'b0}}, win_q[vp_idx].kind};
                OFS_CTL2:  rd_mux = {win_q[vp_idx].en, win_q[vp_idx].bar, {(DW-2){1'b0}}};
                OFS_LBASE: rd_mux = win_q[vp_idx].lbase;
                OFS_UBASE: rd_mux = win_q[vp_idx].ubase;
                OFS_BOUND: rd_mux = win_q[vp_idx].bound;
                OFS_LTGT:  rd_mux = win_q[vp_idx].ltgt;
                OFS_UTGT:  rd_mux = win_q[vp_idx].utgt;
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (rd_req) cfg_rdata <= rd_mux;
    end

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vp_dir <= 1'b0;
            vp_idx <= '0;
            win_q  <= '0;
        end else if (wr_req) begin
            if (cfg_addr == OFS_VIEW) begin
                vp_dir <= cfg_wdata[DW-1];
                vp_idx <= cfg_wdata[IDX_W-1:0];
            end else if (sel_ok) begin
                unique case (cfg_addr)
                    OFS_CTL1:  win_q[vp_idx].kind  <= cfg_wdata[4:0];
                    OFS_CTL2: begin
                        win_q[vp_idx].en  <= cfg_wdata[31];
                        win_q[vp_idx].bar <= cfg_wdata[30];
                    end
                    OFS_LBASE: win_q[vp_idx].lbase <= cfg_wdata;
                    OFS_UBASE: win_q[vp_idx].ubase <= cfg_wdata;
                    OFS_BOUND: win_q[vp_idx].bound <= cfg_wdata;
                    OFS_LTGT:  win_q[vp_idx].ltgt  <= cfg_wdata;
                    OFS_UTGT:  win_q[vp_idx].utgt  <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    a_r3_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> cfg_rvalid);
    a_r3_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !cfg_rvalid);
    a_r10_inbound_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && vp_dir && cfg_addr != OFS_VIEW) |=> $stable(win_q));
    a_r12_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (cfg_addr < OFS_VIEW || cfg_addr > OFS_UTGT)) |=> $stable(win_q));
endmodule

// File: rtl/obx_match.sv
module obx_match
    import obx_pkg::*;
#(
    parameter int unsigned NWIN = 4
) (
    input  win_t [NWIN-1:0]   win_i,
    input  logic [2*DW-1:0]   addr_i,
    output logic [NWIN-1:0]   hit_o
);
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic up_eq, lo_ge, lo_le;
        assign up_eq = (addr_i[2*DW-1:DW] == win_i[g].ubase);
        assign lo_ge = (addr_i[DW-1:0] >= win_i[g].lbase);
        assign lo_le = (addr_i[DW-1:0] <= win_i[g].bound);
        assign hit_o[g] = win_i[g].en && up_eq && lo_ge && lo_le;
    end
endmodule

// File: rtl/obx_resolve.sv
module obx_resolve
    import obx_pkg::*;
#(
    parameter int unsigned NWIN  = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  win_t [NWIN-1:0]     win_i,
    input  logic [NWIN-1:0]     hit_i,
    input  logic                req_i,
    input  logic [2*DW-1:0]     addr_i,
    output logic                xo_valid,
    output logic                xo_hit,
    output logic [IDX_W-1:0]    xo_idx,
    output logic [2*DW-1:0]     xo_addr,
    output logic [4:0]          xo_kind
);
    logic [IDX_W-1:0]  sel;
    logic              any;
    logic [2*DW-1:0]   xl_addr;

    // lowest index wins: scan downward, last assignment sticks
    always_comb begin
        sel = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit_i[i]) sel = IDX_W'(i);
        end
    end

    assign any     = |hit_i;
    assign xl_addr = addr_i - {win_i[sel].ubase, win_i[sel].lbase}
                            + {win_i[sel].utgt,  win_i[sel].ltgt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xo_valid <= 1'b0;
            xo_hit   <= 1'b0;
            xo_idx   <= '0;
            xo_addr  <= '0;
            xo_kind  <= '0;
        end else begin
            xo_valid <= req_i;
            xo_hit   <= req_i && any;
            xo_idx   <= (req_i && any) ? sel : '0;
            xo_addr  <= (req_i && any) ? xl_addr : '0;
            xo_kind  <= (req_i && any) ? win_i[sel].kind : '0;
        end
    end

    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (hit_i[sel] && ((hit_i & ((NWIN'(1) << sel) - NWIN'(1))) == '0)));
    a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> xo_valid);
    a_r9_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i || !any) |=> (!xo_hit && xo_addr == '0 && xo_kind == '0 && xo_idx == '0));
    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && any) |-> win_i[sel].en);
endmodule

// File: rtl/obx_top.sv
module obx_top
    import obx_pkg::*;
#(
    parameter int unsigned NWIN  = 4,
    localparam int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_wr,
    input  logic [11:0]         cfg_addr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic                cfg_rvalid,
    input  logic                xl_valid,
    input  logic [63:0]         xl_addr,
    output logic                xo_valid,
    output logic                xo_hit,
    output logic [IDX_W-1:0]    xo_idx,
    output logic [63:0]         xo_addr,
    output logic [4:0]          xo_kind
);
    win_t [NWIN-1:0]  wins;
    logic [NWIN-1:0]  hits;

    obx_regs #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid),
        .win_o      (wins)
    );

    obx_match #(.NWIN(NWIN)) u_match (
        .win_i  (wins),
        .addr_i (xl_addr),
        .hit_o  (hits)
    );

    obx_resolve #(.NWIN(NWIN), .IDX_W(IDX_W)) u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_i    (wins),
        .hit_i    (hits),
        .req_i    (xl_valid),
        .addr_i   (xl_addr),
        .xo_valid (xo_valid),
        .xo_hit   (xo_hit),
        .xo_idx   (xo_idx),
        .xo_addr  (xo_addr),
        .xo_kind  (xo_kind)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!xo_hit && !cfg_rvalid));
endmodule

// File: tb/obx_top_tb.sv
module obx_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        xl_valid = 1'b0;
    logic [63:0] xl_addr = '0;
    logic        xo_valid, xo_hit;
    logic [1:0]  xo_idx;
    logic [63:0] xo_addr;
    logic [4:0]  xo_kind;

    int n_run = 0, n_fail = 0, cyc = 0;
    string cur_req = "R1";
    bit chk_on = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    obx_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rvalid(cfg_rvalid), .xl_valid(xl_valid), .xl_addr(xl_addr),
        .xo_valid(xo_valid), .xo_hit(xo_hit), .xo_idx(xo_idx),
        .xo_addr(xo_addr), .xo_kind(xo_kind)
    );

    // behavioural reference
    logic [4:0]  m_kind [4];
    logic        m_en [4], m_bar [4];
    logic [31:0] m_lb [4], m_ub [4], m_bd [4], m_lt [4], m_ut [4];
    logic        m_dir;
    logic [1:0]  m_idx;
    logic        e_valid, e_hit, e_rvalid;
    logic [1:0]  e_idx;
    logic [63:0] e_addr;
    logic [4:0]  e_kind;
    logic [31:0] e_rdata;

    function automatic logic [31:0] m_read(input logic [11:0] a);
        if (a == 12'h900) return {m_dir, 29'd0, m_idx};
        if (m_dir) return 32'd0;
        case (a)
            12'h904: return {27'd0, m_kind[m_idx]};
            12'h908: return {m_en[m_idx], m_bar[m_idx], 30'd0};
            12'h90C: return m_lb[m_idx];
            12'h910: return m_ub[m_idx];
            12'h914: return m_bd[m_idx];
            12'h918: return m_lt[m_idx];
            12'h91C: return m_ut[m_idx];
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_kind[i] = 0; m_en[i] = 0; m_bar[i] = 0; m_lb[i] = 0;
                m_ub[i] = 0; m_bd[i] = 0; m_lt[i] = 0; m_ut[i] = 0;
            end
            m_dir = 0; m_idx = 0;
            e_valid = 0; e_hit = 0; e_idx = 0; e_addr = 0; e_kind = 0;
            e_rvalid = 0; e_rdata = 0;
        end else begin
            e_valid = xl_valid; e_hit = 0; e_idx = 0; e_addr = 0; e_kind = 0;
            if (xl_valid) begin
                for (int i = 0; i < 4; i++) begin
                    if (!e_hit && m_en[i] && xl_addr[63:32] == m_ub[i] &&
                        xl_addr[31:0] >= m_lb[i] && xl_addr[31:0] <= m_bd[i]) begin
                        e_hit  = 1;
                        e_idx  = 2'(i);
                        e_addr = xl_addr - {m_ub[i], m_lb[i]} + {m_ut[i], m_lt[i]};
                        e_kind = m_kind[i];
                    end
                end
            end
            e_rvalid = cfg_en && !cfg_wr;
            if (e_rvalid) e_rdata = m_read(cfg_addr);
            if (cfg_en && cfg_wr) begin
                if (cfg_addr == 12'h900) begin
                    m_dir = cfg_wdata[31]; m_idx = cfg_wdata[1:0];
                end else if (!m_dir) begin
                    case (cfg_addr)
                        12'h904: m_kind[m_idx] = cfg_wdata[4:0];
                        12'h908: begin m_en[m_idx] = cfg_wdata[31]; m_bar[m_idx] = cfg_wdata[30]; end
                        12'h90C: m_lb[m_idx] = cfg_wdata;
                        12'h910: m_ub[m_idx] = cfg_wdata;
                        12'h914: m_bd[m_idx] = cfg_wdata;
                        12'h918: m_lt[m_idx] = cfg_wdata;
                        12'h91C: m_ut[m_idx] = cfg_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            n_run++;
            if (xo_valid !== e_valid || xo_hit !== e_hit || xo_idx !== e_idx ||
                xo_addr !== e_addr || xo_kind !== e_kind || cfg_rvalid !== e_rvalid ||
                (e_rvalid && cfg_rdata !== e_rdata)) begin
                n_fail++;
                $display("FAIL %s: got v=%0b h=%0b i=%0d a=%h k=%0d rv=%0b rd=%h exp v=%0b h=%0b i=%0d a=%h k=%0d rv=%0b rd=%h",
                         cur_req, xo_valid, xo_hit, xo_idx, xo_addr, xo_kind, cfg_rvalid, cfg_rdata,
                         e_valid, e_hit, e_idx, e_addr, e_kind, e_rvalid, e_rdata);
            end
        end
    end

    task automatic idle();
        cfg_en = 0; cfg_wr = 0; xl_valid = 0;
        @(negedge clk);
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cfg_en = 1; cfg_wr = 1; cfg_addr = a; cfg_wdata = d; xl_valid = 0;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0;
    endtask
    task automatic rd(input logic [11:0] a);
        cfg_en = 1; cfg_wr = 0; cfg_addr = a; xl_valid = 0;
        @(negedge clk);
        cfg_en = 0;
    endtask
    task automatic xl(input logic [63:0] a);
        xl_valid = 1; xl_addr = a; cfg_en = 0;
        @(negedge clk);
        xl_valid = 0;
    endtask
    task automatic prog(input int w, input logic [4:0] k, input logic [31:0] lb, ub, bd, lt, ut, c2);
        wr(12'h900, 32'(w));
        wr(12'h904, {27'd0, k}); wr(12'h90C, lb); wr(12'h910, ub);
        wr(12'h914, bd); wr(12'h918, lt); wr(12'h91C, ut); wr(12'h908, c2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        // R1: reset state
        cur_req = "R1";
        for (int a = 12'h900; a <= 12'h91C; a += 4) rd(12'(a));
        xl(64'h0); xl(64'h1000_0000);
        // R2: selector
        cur_req = "R2";
        wr(12'h900, 32'h0000_0002); rd(12'h900);
        wr(12'h900, 32'h8000_0003); rd(12'h900);
        // R3: field access through the selector
        cur_req = "R3";
        prog(1, 5'd0, 32'h1000_0000, 32'h0, 32'h1FFF_FFFF, 32'h4000_0000, 32'h1, 32'hC000_0000);
        for (int a = 12'h904; a <= 12'h91C; a += 4) rd(12'(a));
        rd(12'h90C); rd(12'h918); idle(); // back-to-back reads
        // R10: inbound selection
        cur_req = "R10";
        wr(12'h900, 32'h8000_0001); wr(12'h90C, 32'hDEAD_BEEF); wr(12'h908, 32'h0);
        rd(12'h90C); rd(12'h908);
        wr(12'h900, 32'h1); rd(12'h90C); rd(12'h908);
        xl(64'h1000_0000);
        // R12: stray offsets
        cur_req = "R12";
        wr(12'h920, 32'hFFFF_FFFF); wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h920); rd(12'h000); rd(12'h8FC); rd(12'h914);
        // remaining windows
        prog(0, 5'd4, 32'h2000_0000, 32'h0, 32'h2000_0FFF, 32'h0100_0000, 32'h0, 32'h8000_0000);
        prog(2, 5'd2, 32'h3000_0000, 32'h5, 32'h3000_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'h8000_0000);
        prog(3, 5'd5, 32'h1800_0000, 32'h0, 32'h1800_FFFF, 32'h0213_0000, 32'h0, 32'h8000_0000);
        // R5: boundaries
        cur_req = "R5";
        xl(64'h1000_0000); xl(64'h1FFF_FFFF); xl(64'h0FFF_FFFF);
        xl(64'h2000_1000); xl(64'h0000_0001_1000_0000); xl(64'h3000_0010);
        // R6: offset and wrap
        cur_req = "R6";
        xl(64'h1234_5678); xl(64'h5_3000_0020); xl(64'h5_3000_0000);
        // R7: kinds and config routing
        cur_req = "R7";
        xl(64'h2000_0ABC); xl(64'h1800_0004); xl(64'h5_3000_FFFF);
        // R8: overlap
        cur_req = "R8";
        xl(64'h1800_0004); xl(64'h1800_FFFF);
        wr(12'h900, 32'h1); wr(12'h908, 32'h0);
        xl(64'h1800_0004);
        // R4: bar bit alone does not enable
        cur_req = "R4";
        wr(12'h908, 32'h4000_0000); rd(12'h908); xl(64'h1000_0000);
        wr(12'h908, 32'hC000_0000); xl(64'h1000_0000);
        // R9: misses and no request
        cur_req = "R9";
        xl(64'hFFFF_FFFF_FFFF_FFFF); idle(); idle();
        // R11: same-cycle write and request
        cur_req = "R11";
        wr(12'h900, 32'h0);
        cfg_en = 1; cfg_wr = 1; cfg_addr = 12'h908; cfg_wdata = 32'h0;
        xl_valid = 1; xl_addr = 64'h2000_0000;
        @(negedge clk);
        cfg_en = 0; cfg_wr = 0;
        xl(64'h2000_0000);
        cfg_en = 1; cfg_wr = 0; cfg_addr = 12'h908; xl_valid = 1; xl_addr = 64'h1000_0004;
        @(negedge clk);
        idle(); idle();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got cycle %0d expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule